// File: doc/BRIEF.md
# Pin configuration and grouped interrupt controller

This block holds one 32-bit configuration word for each general-purpose pin and turns it into pad-control outputs. In the same word, a three-bit mode field chooses between driving the pin and one of several input behaviours. The input behaviours are: input with no interrupt, interrupt on a high level, interrupt on a low level, interrupt on a rising edge, interrupt on a falling edge, and interrupt on either edge. To mask an interrupt, software writes the quiet input mode to the pin. To unmask it, software writes the trigger mode back. No separate mask register exists.

Each pin input passes through a two-flop synchroniser, and the events are detected on the synchronised samples. Each pin is assigned to one of eight interrupt groups. An event on a pin sets that pin's bit in the pending bank of its own group, and no other group sees it. Each group has one interrupt line, which is high while any pending bit of that group is set. Pending bits are cleared by writing 1 to them. A simple register port gives access to both the configuration words and the pending banks. A write takes effect on the clock edge. A read returns the word at the same address combinationally.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every configuration word reads 0, every interrupt line is low, and pad_out and pad_oe are 0 for every pin.
- R2: The configuration word of pin n is at byte address 4*n for n below NPINS. Only the bits in mask 0x00E78FEF are stored, and all other bits read as 0. Field positions are: bit 0 data, bits 3:1 mode, bits 6:5 function, bits 8:7 pull, bit 9 input enable, bits 11:10 drive low part, bit 15 Schmitt, bits 18:16 group, bit 21 lock, bits 23:22 drive high part.
- R3: In mode 1 (drive), bit 0 reads back the stored value. In every other mode, bit 0 reads the pin level after the two-flop synchroniser. A pin change made between clock edges is visible after the second rising edge and not after the first.
- R4: Edge modes set the pending bit: mode 4 on a rising synchronised edge, mode 5 on a falling edge, mode 6 on either edge.
- R5: Level modes assert the event on every cycle the level holds: mode 2 while the pin is high, mode 3 while it is low. A clear written while the level holds leaves the bit set.
- R6: Modes 0, 1 and 7 never set a pending bit.
- R7: The pending bit of pin p in group g is at byte address 0x800 + 0x40*g + 4*(p/32), at bit p%32. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. A pending bit stays set until it is cleared.
- R8: An event sets a pending bit only in the group held in the pin's bits 18:16. Interrupt line g is the OR of all pending bits of group g.
- R9: When an event and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R10: While a pin's lock bit (bit 21) is set, a write to that word that has bit 21 set is ignored. A write that has bit 21 clear is accepted in full.
- R11: The pad outputs of pin n are as follows. pad_out is bit 0. pad_oe is 1 only when the mode is 1 and the function is 0. pad_func is bits 6:5. pad_pull is bits 8:7. pad_ie is bit 9. pad_schmitt is bit 15. pad_drive is {bits 23:22, bits 11:10}.
- R12: Undecoded addresses read as 0, and writes to them change nothing. Undecoded addresses are: pin words at or above NPINS, pending words with a group at or above NGROUPS, pending words at or above ceil(NPINS/32), and pending addresses with bits 10:9 non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 12 | Byte address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data at addr, combinational |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| pad_out | output | NPINS | Output level per pin |
| pad_oe | output | NPINS | Output enable per pin |
| pad_func | output | 2*NPINS | Function select, 2 bits per pin |
| pad_pull | output | 2*NPINS | Pull select, 2 bits per pin |
| pad_ie | output | NPINS | Input enable per pin |
| pad_schmitt | output | NPINS | Schmitt enable per pin |
| pad_drive | output | 4*NPINS | Drive strength, 4 bits per pin |
| irq | output | NGROUPS | One interrupt line per group |

## Verification
A detected event and a write-1 clear of the same pending bit can land in the same cycle. The bench provokes this in two ways. First, it times a clear write onto the exact rising edge where an either-edge event reaches the pending bank, which is the third edge after the pin change. Second, it clears a level-high pin while that pin is still held high. In both cases the pending word is read back and must still show the bit set. A following clear, made with no event, must then empty it. The sweep over modes, starting levels, group assignments and pins on both sides of the 32-bit word boundary checks the pending word and the whole interrupt vector against values computed from the mode table.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int          ADDR_W   = 12;
  localparam logic [31:0] CFG_MASK = 32'h00E7_8FEF;

  localparam int B_DATA = 0;
  localparam int B_MODE = 1;
  localparam int B_FUNC = 5;
  localparam int B_PULL = 7;
  localparam int B_IE   = 9;
  localparam int B_DRVL = 10;
  localparam int B_ST   = 15;
  localparam int B_GRP  = 16;
  localparam int B_LOCK = 21;
  localparam int B_DRVH = 22;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_DRIVE  = 3'd1,
    M_LVL_HI = 3'd2,
    M_LVL_LO = 3'd3,
    M_RISE   = 3'd4,
    M_FALL   = 3'd5,
    M_BOTH   = 3'd6,
    M_QUIET  = 3'd7
  } trig_e;

  function automatic logic trig_hit(input logic [2:0] mode, input logic now_v,
                                    input logic old_v);
    logic hit;
    case (trig_e'(mode))
      M_LVL_HI: hit = now_v;
      M_LVL_LO: hit = !now_v;
      M_RISE:   hit = now_v && !old_v;
      M_FALL:   hit = !now_v && old_v;
      M_BOTH:   hit = now_v ^ old_v;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prv
);
  logic [WIDTH-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur = sync_q;
  assign prv = hist_q;
endmodule

// File: rtl/pinbank_cfg.sv
module pinbank_cfg
  import pinbank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wr_data,
  output logic [NPINS-1:0][31:0] cfg
);
  localparam int PIDX_W = ADDR_W - 3;

  logic [PIDX_W-1:0] pin_idx;
  logic              pin_region;
  logic              unused_lsb;

  assign pin_idx    = addr[ADDR_W-2:2];
  assign pin_region = wr_en && !addr[ADDR_W-1];
  assign unused_lsb = ^addr[1:0];

  for (genvar n = 0; n < NPINS; n++) begin : g_word
    logic hit, blocked;
    assign hit     = pin_region && (pin_idx == PIDX_W'(n));
    assign blocked = cfg[n][B_LOCK] && wr_data[B_LOCK];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg[n] <= '0;
      else if (hit && !blocked)  cfg[n] <= wr_data & CFG_MASK;
    end
  end
endmodule

// File: rtl/pinbank_pend.sv
module pinbank_pend
  import pinbank_pkg::*;
#(
  parameter int NPINS   = 8,
  parameter int NGROUPS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wr_data,
  input  logic [NPINS-1:0]            evt,
  input  logic [NPINS-1:0][2:0]       grp,
  output logic [NGROUPS-1:0][NPINS-1:0] pend,
  output logic [NGROUPS-1:0]          irq
);
  logic       clr_sel;
  logic [2:0] g_idx;
  logic [3:0] w_idx;
  logic       unused_lsb;

  assign clr_sel    = wr_en && addr[ADDR_W-1] && (addr[10:9] == 2'b00);
  assign g_idx      = addr[8:6];
  assign w_idx      = addr[5:2];
  assign unused_lsb = ^addr[1:0];

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    for (genvar p = 0; p < NPINS; p++) begin : g_bit
      logic set_b, clr_b;
      assign set_b = evt[p] && (grp[p] == 3'(g));
      assign clr_b = clr_sel && (g_idx == 3'(g)) && (w_idx == 4'(p / 32))
                     && wr_data[p % 32];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend[g][p] <= 1'b0;
        else        pend[g][p] <= set_b || (pend[g][p] && !clr_b);
      end
    end
    assign irq[g] = |pend[g];
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS   = 40,
  parameter int NGROUPS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [2*NPINS-1:0]   pad_func,
  output logic [2*NPINS-1:0]   pad_pull,
  output logic [NPINS-1:0]     pad_ie,
  output logic [NPINS-1:0]     pad_schmitt,
  output logic [4*NPINS-1:0]   pad_drive,
  output logic [NGROUPS-1:0]   irq
);
  localparam int NWORDS = (NPINS + 31) / 32;
  localparam int PIDX_W = ADDR_W - 3;

  logic [NPINS-1:0][31:0]         cfg_q;
  logic [NGROUPS-1:0][NPINS-1:0]  pend_q;
  logic [NPINS-1:0]               sync_cur, sync_prv, evt;
  logic [NPINS-1:0][2:0]          grp;

  pinbank_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(sync_cur), .prv(sync_prv)
  );

  pinbank_cfg #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .cfg(cfg_q)
  );

  pinbank_pend #(.NPINS(NPINS), .NGROUPS(NGROUPS)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .evt(evt), .grp(grp), .pend(pend_q), .irq(irq)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [2:0] mode;
    assign mode   = cfg_q[p][B_MODE +: 3];
    assign evt[p] = trig_hit(mode, sync_cur[p], sync_prv[p]);
    assign grp[p] = cfg_q[p][B_GRP +: 3];

    assign pad_out[p]         = cfg_q[p][B_DATA];
    assign pad_oe[p]          = (mode == M_DRIVE) && (cfg_q[p][B_FUNC +: 2] == 2'b00);
    assign pad_func[2*p +: 2] = cfg_q[p][B_FUNC +: 2];
    assign pad_pull[2*p +: 2] = cfg_q[p][B_PULL +: 2];
    assign pad_ie[p]          = cfg_q[p][B_IE];
    assign pad_schmitt[p]     = cfg_q[p][B_ST];
    assign pad_drive[4*p +: 4] = {cfg_q[p][B_DRVH +: 2], cfg_q[p][B_DRVL +: 2]};
  end

  logic [PIDX_W-1:0] rd_pin;
  logic [2:0]        rd_grp;
  logic [3:0]        rd_word;
  logic              rd_pend_ok;
  logic              unused_lsb;

  assign rd_pin     = addr[ADDR_W-2:2];
  assign rd_grp     = addr[8:6];
  assign rd_word    = addr[5:2];
  assign rd_pend_ok = addr[ADDR_W-1] && (addr[10:9] == 2'b00)
                      && (rd_word < 4'(NWORDS));
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    rd_data = '0;
    if (!addr[ADDR_W-1]) begin
      for (int n = 0; n < NPINS; n++) begin
        if (rd_pin == PIDX_W'(n)) begin
          rd_data = cfg_q[n];
          if (cfg_q[n][B_MODE +: 3] != M_DRIVE) rd_data[B_DATA] = sync_cur[n];
        end
      end
    end else if (rd_pend_ok) begin
      for (int g = 0; g < NGROUPS; g++) begin
        for (int p = 0; p < NPINS; p++) begin
          if (rd_grp == 3'(g) && rd_word == 4'(p / 32)) rd_data[p % 32] = pend_q[g][p];
        end
      end
    end
  end
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int NPINS   = 40,
  parameter int NGROUPS = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [11:0]                 addr,
  input logic [31:0]                 wr_data,
  input logic [NGROUPS-1:0]          irq,
  input logic [NPINS-1:0][31:0]      cfg_q,
  input logic [NGROUPS-1:0][NPINS-1:0] pend_q,
  input logic [NPINS-1:0]            sync_cur
);
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[g] && !(wr_en && addr[11])) |=> irq[g]); // R7

    for (genvar p = 0; p < NPINS; p++) begin : g_bit
      AST_GROUP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[g][p]) |-> ($past(cfg_q[p][18:16]) == 3'(g))); // R8

      AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[g][p]) |-> ($past(cfg_q[p][3:1]) >= 3'd2 &&
                                 $past(cfg_q[p][3:1]) <= 3'd6)); // R6

      AST_LEVEL_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[p][3:1] == 3'd2 && sync_cur[p] && cfg_q[p][18:16] == 3'(g))
        |=> pend_q[g][p]); // R5
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_lock
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr[11] && addr[10:2] == 9'(p) && cfg_q[p][21] && wr_data[21])
      |=> $stable(cfg_q[p])); // R10
  end
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS), .NGROUPS(NGROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .irq(irq), .cfg_q(cfg_q), .pend_q(pend_q), .sync_cur(sync_cur)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;
  localparam int NP = 40;
  localparam int NG = 8;
  localparam logic [31:0] MASK = 32'h00E7_8FEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_ie, pad_schmitt;
  logic [2*NP-1:0] pad_func, pad_pull;
  logic [4*NP-1:0] pad_drive;
  logic [NG-1:0] irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pinbank_ctrl #(.NPINS(NP), .NGROUPS(NG)) u_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_func(pad_func), .pad_pull(pad_pull), .pad_ie(pad_ie),
    .pad_schmitt(pad_schmitt), .pad_drive(pad_drive), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] pa(input int g, input int p);
    return 12'(32'h800 + g * 64 + (p / 32) * 4);
  endfunction

  function automatic logic exp_hit(input int m, input logic s0, input logic s1);
    case (m)
      2, 3:    return 1'b1;
      4:       return !s0 && s1;
      5:       return s0 && !s1;
      6:       return s0 != s1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic clear_all();
    for (int g = 0; g < NG; g++)
      for (int w = 0; w < 2; w++) wr(12'(32'h800 + g * 64 + w * 4), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, v, e;
    int pl[4] = '{0, 31, 32, 39};

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    for (int n = 0; n < NP; n++) begin
      rd(12'(4 * n), r);
      chk("R1 cfg word", r, 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 pad_oe", 32'(pad_oe[31:0]) | 32'(pad_oe[NP-1:32]), 32'h0);
    chk("R1 pad_out", 32'(pad_out[31:0]) | 32'(pad_out[NP-1:32]), 32'h0);

    // R2 / R11: storage sweep and pad decode
    for (int n = 0; n < NP; n++) begin
      v = (32'(n) * 32'h9E37_79B1) ^ 32'h5A5A_A5A5;
      v = v & MASK & ~(32'h1 << 21);
      wr(12'(4 * n), v | ~MASK);
      rd(12'(4 * n), r);
      e = v;
      if (v[3:1] != 3'd1) e[0] = 1'b0;
      chk("R2 readback", r, e);
      chk("R11 pads",
          32'({pad_out[n], pad_oe[n], pad_func[2*n +: 2], pad_pull[2*n +: 2],
               pad_ie[n], pad_schmitt[n], pad_drive[4*n +: 4]}),
          32'({v[0], (v[3:1] == 3'd1 && v[6:5] == 2'b00), v[6:5], v[8:7],
               v[9], v[15], v[23:22], v[11:10]}));
    end
    for (int n = 0; n < NP; n++) wr(12'(4 * n), 32'h0);
    clear_all();
    chk("R8 irq empty after sweep", 32'(irq), 32'h0);

    // R12: undecoded space
    rd(12'(4 * NP), r);
    chk("R12 pin word beyond NPINS", r, 32'h0);
    wr(12'(4 * NP), 32'hFFFF_FFFF);
    rd(12'(4 * NP), r);
    chk("R12 write beyond NPINS", r, 32'h0);
    rd(12'(4 * (NP - 1)), r);
    chk("R12 last pin untouched", r, 32'h0);
    rd(12'h808, r);
    chk("R12 pending word out of range", r, 32'h0);
    rd(12'hA00, r);
    chk("R12 pending high bits", r, 32'h0);

    // R3: synchroniser latency and data bit source
    wr(12'd20, 32'hE);
    pin_in[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(12'd20, r);
    chk("R3 one edge after change", r, 32'hE);
    @(posedge clk); @(negedge clk);
    rd(12'd20, r);
    chk("R3 two edges after change", r, 32'hF);
    wr(12'd20, 32'h2);
    rd(12'd20, r);
    chk("R3 drive mode returns stored data", r, 32'h2);
    pin_in[5] = 1'b0;
    wr(12'd20, 32'h0);

    // R4 / R6 / R8: mode x level x pin sweep
    for (int i = 0; i < 4; i++) begin
      for (int m = 0; m < 8; m++) begin
        for (int s = 0; s < 2; s++) begin
          int p, g;
          logic h;
          p = pl[i];
          g = (p + m) % NG;
          pin_in[p] = s[0];
          wr(12'(4 * p), 32'hE);
          idle(4);
          wr(12'(4 * p), 32'(m << 1) | 32'(g << 16));
          idle(4);
          wr(pa(g, p), 32'h1 << (p % 32));
          pin_in[p] = !s[0];
          idle(5);
          h = exp_hit(m, s[0], !s[0]);
          rd(pa(g, p), r);
          chk((m >= 4 && m <= 6) ? "R4 edge pending" : (m >= 2 ? "R5 level pending" : "R6 quiet pending"),
              (r >> (p % 32)) & 32'h1, 32'(h));
          chk("R8 irq vector", 32'(irq), h ? (32'h1 << g) : 32'h0);
          wr(12'(4 * p), 32'hE);
          pin_in[p] = 1'b0;
          idle(4);
          wr(pa(g, p), 32'hFFFF_FFFF);
        end
      end
    end
    chk("R8 irq idle after sweep", 32'(irq), 32'h0);

    // R7: write-1 clear, zeros leave bits
    wr(12'(4 * 33), 32'h0003_0008);
    wr(12'(4 * 34), 32'h0003_0008);
    idle(2);
    pin_in[33] = 1'b1; pin_in[34] = 1'b1;
    idle(5);
    rd(pa(3, 33), r);
    chk("R7 two pending bits", r, 32'h6);
    wr(pa(3, 33), 32'h2);
    rd(pa(3, 33), r);
    chk("R7 clear one bit", r, 32'h4);
    chk("R7 irq still high", 32'(irq), 32'h8);
    wr(pa(3, 33), 32'h4);
    rd(pa(3, 33), r);
    chk("R7 clear second bit", r, 32'h0);
    chk("R7 irq low", 32'(irq), 32'h0);
    wr(12'(4 * 33), 32'hE); wr(12'(4 * 34), 32'hE);
    pin_in[33] = 1'b0; pin_in[34] = 1'b0;
    idle(4);
    wr(12'(4 * 33), 32'h0); wr(12'(4 * 34), 32'h0);

    // R5 / R9: clear during active level
    wr(12'd12, 32'h0001_0004);
    pin_in[3] = 1'b1;
    idle(5);
    wr(pa(1, 3), 32'h8);
    rd(pa(1, 3), r);
    chk("R5 clear during held level", r, 32'h8);
    pin_in[3] = 1'b0;
    idle(5);
    wr(pa(1, 3), 32'h8);
    rd(pa(1, 3), r);
    chk("R5 clear after level drops", r, 32'h0);
    chk("R5 irq low", 32'(irq), 32'h0);
    wr(12'd12, 32'h0);

    // R9: clear lands on the edge event cycle
    wr(12'd40, 32'h0002_000C);
    idle(3);
    pin_in[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(pa(2, 10), 32'h400);
    rd(pa(2, 10), r);
    chk("R9 set beats clear", r, 32'h400);
    wr(pa(2, 10), 32'h400);
    rd(pa(2, 10), r);
    chk("R9 later clear empties", r, 32'h0);
    wr(12'd40, 32'hE);
    pin_in[10] = 1'b0;
    idle(4);
    wr(12'd40, 32'h0);

    // R10: lock
    wr(12'd28, 32'h0020_0003);
    wr(12'd28, 32'h0020_0002);
    rd(12'd28, r);
    chk("R10 locked write ignored", r, 32'h0020_0003);
    chk("R10 pad_out held", 32'(pad_out[7]), 32'h1);
    wr(12'd28, 32'h0000_0004);
    rd(12'd28, r);
    chk("R10 unlocking write accepted", r, 32'h4);
    chk("R10 pad_out follows", 32'(pad_out[7]), 32'h0);
    wr(12'd28, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule